// File: doc/BRIEF.md
# Physical Memory Region Permission Checker

This block decides whether one memory access may proceed under a set of protection entries. Each entry holds an 8-bit configuration byte and a word address. The block turns every entry into an inclusive byte range, scans the entries from index 0 upward, and reports whether the access is allowed together with the read/write/execute set that was granted.

The caller gives the first byte address, the byte count, the requested permissions and whether the access comes from machine mode. Two security-policy bits are also inputs. The first makes unmatched accesses fail for every mode. The second enables a locked-down permission table. The configuration and the policy bits are held outside the block. The block computes its decision combinationally and registers it on the cycle it sees a request strobe.

Top module: `pmp_access_checker`

## Requirements
- R1: Configuration byte layout: bit 0 read, bit 1 write, bit 2 execute, bits 4:3 range form (0 off, 1 top-of-range, 2 four-byte, 3 naturally aligned power of two), bit 7 lock. Bits 6:5 are ignored. An entry whose form is off never decides an access.
- R2: In the power-of-two form, with t = {addr, 2'b11}, the range runs from t & (t+1) to t | (t+1).
- R3: In the top-of-range form, the range runs from the previous entry's address times 4 up to the entry's own address times 4 minus 1. Entry 0 starts at 0. If the start exceeds the end, the range collapses to the single byte 0.
- R4: The four-byte form covers the bytes addr*4 through addr*4+3.
- R5: The last byte of the access is req_addr + req_size - 1. The lowest-indexed active entry that holds both the first and the last byte decides the result.
- R6: If, while scanning, an entry holds exactly one of the first and last bytes, the access is denied with an empty granted set.
- R7: With the lockdown bit clear, a deciding entry grants RWX to machine mode when its lock bit is clear. In every other case it grants its own R/W/X bits.
- R8: With the lockdown bit set and machine mode, the index {L,R,W,X} grants RW for 2, 3 and 14, X for 9 and 10, RX for 11 and 13, R for 12 and 15, and nothing for any other index.
- R9: With the lockdown bit set and a non-machine mode, the index grants X for 1, 10 and 11, R for 2, 4 and 15, RW for 3 and 6, RX for 5, RWX for 7, and nothing for any other index.
- R10: When no entry decides the access, the policy bits set the result. With the deny-all bit set, the access is denied and nothing is granted. Otherwise, with the lockdown bit set, machine mode is allowed with RW when X is not requested, and every other request is denied with nothing granted. Otherwise machine mode is allowed with RWX, and other modes are denied with nothing granted.
- R11: When an entry decides, the access is allowed exactly when every requested bit is in the granted set.
- R12: Results appear on rsp_allow/rsp_perm with rsp_valid one clock after req_valid. Without a request, the outputs hold their values and rsp_valid is low. Reset clears all three outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| entry_cfg | input | NUM_ENTRIES*8 | Configuration bytes; entry i in bits [8i+7:8i] |
| entry_addr | input | NUM_ENTRIES*ADDR_W | Word addresses; entry i in bits [ADDR_W*i +: ADDR_W] |
| deny_default | input | 1 | Deny-all policy bit for unmatched accesses |
| lockdown | input | 1 | Locked-down permission table enable |
| req_valid | input | 1 | Request strobe |
| req_addr | input | ADDR_W+2 | First byte address of the access |
| req_size | input | SIZE_W | Byte count of the access |
| req_perm | input | 3 | Requested permissions {X,W,R} |
| req_machine | input | 1 | Access comes from machine mode |
| rsp_valid | output | 1 | Result strobe |
| rsp_allow | output | 1 | Access allowed |
| rsp_perm | output | 3 | Granted permissions {X,W,R} |

## Verification
The decision for a request driven before clock edge k is registered at edge k and is read at the following falling edge. So every result is due exactly one cycle after its strobe. The driver applies each request at a falling edge and queues its hand-derived expectation. The monitor pops that expectation at each falling edge where rsp_valid is high, so back-to-back requests are compared in order, and a missing or extra result is reported. Configuration changes are applied only after the edge that sampled the previous request. Hold behaviour is checked after several idle cycles with different inputs applied.

// File: rtl/pmp_access_checker.sv
module pmp_access_checker #(
  parameter int NUM_ENTRIES = 8,
  parameter int ADDR_W      = 30,
  parameter int SIZE_W      = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_ENTRIES*8-1:0]      entry_cfg,
  input  logic [NUM_ENTRIES*ADDR_W-1:0] entry_addr,
  input  logic                          deny_default,
  input  logic                          lockdown,
  input  logic                          req_valid,
  input  logic [ADDR_W+1:0]             req_addr,
  input  logic [SIZE_W-1:0]             req_size,
  input  logic [2:0]                    req_perm,
  input  logic                          req_machine,
  output logic                          rsp_valid,
  output logic                          rsp_allow,
  output logic [2:0]                    rsp_perm
);
  localparam int BW = ADDR_W + 2;

  typedef enum logic [1:0] {FORM_OFF, FORM_TOR, FORM_NA4, FORM_NAPOT} form_e;

  function automatic logic [2:0] lock_tab_m(input logic [3:0] k);
    case (k)
      4'd2, 4'd3, 4'd14: return 3'b011;
      4'd9, 4'd10:       return 3'b100;
      4'd11, 4'd13:      return 3'b101;
      4'd12, 4'd15:      return 3'b001;
      default:           return 3'b000;
    endcase
  endfunction

  function automatic logic [2:0] lock_tab_u(input logic [3:0] k);
    case (k)
      4'd1, 4'd10, 4'd11: return 3'b100;
      4'd2, 4'd4, 4'd15:  return 3'b001;
      4'd3, 4'd6:         return 3'b011;
      4'd5:               return 3'b101;
      4'd7:               return 3'b111;
      default:            return 3'b000;
    endcase
  endfunction

  logic [BW-1:0] last_byte;
  assign last_byte = req_addr + BW'(req_size) - BW'(1);

  logic [NUM_ENTRIES-1:0]      in_first, in_last, active;
  logic [NUM_ENTRIES-1:0][2:0] grant;

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
    logic [7:0]    cfg;
    form_e         form;
    logic [BW-1:0] own_b, prev_b, nap_t, tor_hi, lo, hi;
    logic          unused_rsvd;

    assign cfg         = entry_cfg[i*8 +: 8];
    assign form        = form_e'(cfg[4:3]);
    assign unused_rsvd = ^cfg[6:5];
    assign own_b       = {entry_addr[i*ADDR_W +: ADDR_W], 2'b00};
    assign nap_t       = own_b | BW'(3);
    assign tor_hi      = own_b - BW'(1);

    if (i == 0) begin : g_first
      assign prev_b = '0;
    end else begin : g_rest
      assign prev_b = {entry_addr[(i-1)*ADDR_W +: ADDR_W], 2'b00};
    end

    always_comb begin
      case (form)
        FORM_TOR: begin
          if (prev_b > tor_hi) begin
            lo = '0;
            hi = '0;
          end else begin
            lo = prev_b;
            hi = tor_hi;
          end
        end
        FORM_NA4: begin
          lo = own_b;
          hi = own_b + BW'(3);
        end
        FORM_NAPOT: begin
          lo = nap_t & (nap_t + BW'(1));
          hi = nap_t | (nap_t + BW'(1));
        end
        default: begin
          lo = '0;
          hi = '1;
        end
      endcase
    end

    assign in_first[i] = (req_addr >= lo) && (req_addr <= hi);
    assign in_last[i]  = (last_byte >= lo) && (last_byte <= hi);
    assign active[i]   = (form != FORM_OFF);
    assign grant[i]    = lockdown
                         ? (req_machine ? lock_tab_m({cfg[7], cfg[0], cfg[1], cfg[2]})
                                        : lock_tab_u({cfg[7], cfg[0], cfg[1], cfg[2]}))
                         : ((req_machine && !cfg[7]) ? 3'b111 : cfg[2:0]);
  end

  logic       decided, allow_c;
  logic [2:0] perm_c;

  always_comb begin
    decided = 1'b0;
    allow_c = 1'b0;
    perm_c  = 3'b000;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (!decided) begin
        if (in_first[i] ^ in_last[i]) begin
          decided = 1'b1;
        end else if (in_first[i] && active[i]) begin
          decided = 1'b1;
          perm_c  = grant[i];
          allow_c = (req_perm & ~grant[i]) == 3'b000;
        end
      end
    end
    if (!decided) begin
      if (deny_default) begin
        allow_c = 1'b0;
      end else if (lockdown) begin
        if (req_machine && !req_perm[2]) begin
          allow_c = 1'b1;
          perm_c  = 3'b011;
        end
      end else if (req_machine) begin
        allow_c = 1'b1;
        perm_c  = 3'b111;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_allow <= 1'b0;
      rsp_perm  <= 3'b000;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_allow <= allow_c;
        rsp_perm  <= perm_c;
      end
    end
  end
endmodule

// File: rtl/pmp_access_checker_chk.sv
module pmp_access_checker_chk #(
  parameter int NUM_ENTRIES = 8,
  parameter int ADDR_W      = 30,
  parameter int SIZE_W      = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NUM_ENTRIES*8-1:0] entry_cfg,
  input logic                     deny_default,
  input logic                     req_valid,
  input logic [2:0]               req_perm,
  input logic                     rsp_valid,
  input logic                     rsp_allow,
  input logic [2:0]               rsp_perm
);
  localparam logic [NUM_ENTRIES*8-1:0] FORM_MASK = {NUM_ENTRIES{8'h18}};

  logic any_on;
  assign any_on = |(entry_cfg & FORM_MASK);

  // R12
  result_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid && $stable(rsp_allow) && $stable(rsp_perm));

  // R11
  allow_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (!rsp_allow || (($past(req_perm) & ~rsp_perm) == 3'b000)));

  // R10
  deny_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && deny_default && !any_on) |=> (!rsp_allow && rsp_perm == 3'b000));
endmodule

bind pmp_access_checker pmp_access_checker_chk #(
  .NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .entry_cfg(entry_cfg), .deny_default(deny_default),
  .req_valid(req_valid), .req_perm(req_perm), .rsp_valid(rsp_valid),
  .rsp_allow(rsp_allow), .rsp_perm(rsp_perm)
);

// File: tb/pmp_access_checker_test.sv
`timescale 1ns/1ps
module pmp_access_checker_test;
  localparam int N  = 8;
  localparam int AW = 30;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    cfg [N];
  logic [AW-1:0] ea  [N];
  logic [N*8-1:0]  entry_cfg;
  logic [N*AW-1:0] entry_addr;
  logic          deny_default = 1'b0, lockdown = 1'b0;
  logic          req_valid = 1'b0, req_machine = 1'b0;
  logic [31:0]   req_addr = '0;
  logic [3:0]    req_size = 4'd0;
  logic [2:0]    req_perm = 3'b000;
  logic          rsp_valid, rsp_allow;
  logic [2:0]    rsp_perm;

  int checks = 0, errors = 0;
  bit done = 0;
  bit       q_allow [$];
  bit [2:0] q_perm  [$];
  string    q_tag   [$];

  always #4 clk = ~clk;

  always_comb
    for (int i = 0; i < N; i++) begin
      entry_cfg[i*8 +: 8]   = cfg[i];
      entry_addr[i*AW +: AW] = ea[i];
    end

  pmp_access_checker uut (
    .clk(clk), .rst_n(rst_n), .entry_cfg(entry_cfg), .entry_addr(entry_addr),
    .deny_default(deny_default), .lockdown(lockdown), .req_valid(req_valid),
    .req_addr(req_addr), .req_size(req_size), .req_perm(req_perm),
    .req_machine(req_machine), .rsp_valid(rsp_valid), .rsp_allow(rsp_allow),
    .rsp_perm(rsp_perm)
  );

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic clear_entries();
    for (int i = 0; i < N; i++) begin
      cfg[i] = 8'h00;
      ea[i]  = '0;
    end
  endtask

  // drives one request at the current falling edge, queues its expectation
  task automatic send(input string tag, input logic [31:0] a, input logic [3:0] sz,
                      input logic [2:0] p, input logic m,
                      input bit x_allow, input bit [2:0] x_perm);
    req_addr = a; req_size = sz; req_perm = p; req_machine = m; req_valid = 1'b1;
    q_allow.push_back(x_allow);
    q_perm.push_back(x_perm);
    q_tag.push_back(tag);
    @(negedge clk);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rsp_valid) begin
        checks++;
        if (q_tag.size() == 0) begin
          errors++;
          $display("FAIL R12 unexpected result allow=%0b perm=%0d expected none",
                   rsp_allow, rsp_perm);
        end else begin
          string t;
          bit ea_, ep_chk;
          bit [2:0] ep;
          t = q_tag.pop_front();
          ea_ = q_allow.pop_front();
          ep = q_perm.pop_front();
          ep_chk = (rsp_allow === ea_) && (rsp_perm === ep);
          if (!ep_chk) begin
            errors++;
            $display("FAIL %s allow=%0b perm=%0d expected allow=%0b perm=%0d",
                     t, rsp_allow, rsp_perm, ea_, ep);
          end
        end
      end
    end
  end

  initial begin
    #(8 * 20000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    clear_entries();
    repeat (3) @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0 || rsp_allow !== 1'b0 || rsp_perm !== 3'b000) begin
      errors++;
      $display("FAIL R12 reset outputs %0b/%0b/%0d expected 0/0/0",
               rsp_valid, rsp_allow, rsp_perm);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // four-byte, top-of-range, power-of-two and collapsed ranges
    cfg[0] = 8'h13; ea[0] = 30'h800;   // 0x2000..0x2003 RW
    cfg[1] = 8'h0D; ea[1] = 30'hC00;   // 0x2000..0x2FFF RX
    cfg[2] = 8'h99; ea[2] = 30'h11FF;  // 0x4000..0x4FFF R locked
    cfg[3] = 8'h69; ea[3] = 30'h100;   // collapses to byte 0, R; reserved bits set (R1)
    send("R4 R5 four-byte wins over later entry", 32'h2000, 4, 3'b001, 0, 1, 3'b011);
    send("R3 R11 top-of-range write refused",      32'h2004, 4, 3'b010, 0, 0, 3'b101);
    send("R3 top-of-range exec at end",            32'h2FFC, 4, 3'b100, 0, 1, 3'b101);
    send("R6 straddles range end",                 32'h2FFE, 4, 3'b001, 0, 0, 3'b000);
    send("R4 R6 straddles four-byte range",        32'h2002, 4, 3'b001, 0, 0, 3'b000);
    send("R2 power-of-two start",                  32'h4000, 8, 3'b001, 0, 1, 3'b001);
    send("R2 power-of-two end",                    32'h4FF8, 8, 3'b001, 0, 1, 3'b001);
    send("R2 R6 power-of-two straddle",            32'h4FFC, 8, 3'b001, 0, 0, 3'b000);
    send("R10 user no match",                      32'h5000, 4, 3'b001, 0, 0, 3'b000);
    send("R7 locked entry binds machine",          32'h4100, 4, 3'b010, 1, 0, 3'b001);
    send("R7 unlocked entry machine full",         32'h2004, 4, 3'b010, 1, 1, 3'b111);
    send("R10 machine no match",                   32'h9000, 4, 3'b111, 1, 1, 3'b111);
    send("R1 R3 collapsed range byte 0",           32'h0000, 1, 3'b001, 0, 1, 3'b001);
    send("R3 R6 collapsed range straddle",         32'h0000, 2, 3'b001, 0, 0, 3'b000);

    clear_entries();
    cfg[0] = 8'h0B; ea[0] = 30'h40;    // entry 0 top-of-range 0..0xFF RW
    send("R3 entry 0 starts at zero",              32'h0080, 4, 3'b010, 0, 1, 3'b011);
    send("R3 above entry 0 range",                 32'h0100, 4, 3'b001, 0, 0, 3'b000);

    clear_entries();
    ea[0] = 30'h11FF;
    lockdown = 1'b1;
    cfg[0] = 8'h9B;
    send("R8 index 14 machine",                    32'h4000, 4, 3'b001, 1, 1, 3'b011);
    send("R9 index 14 user",                       32'h4000, 4, 3'b001, 0, 0, 3'b000);
    cfg[0] = 8'h9A;
    send("R8 index 10 machine",                    32'h4000, 4, 3'b100, 1, 1, 3'b100);
    send("R9 index 10 user",                       32'h4000, 4, 3'b100, 0, 1, 3'b100);
    cfg[0] = 8'h1F;
    send("R9 index 7 user",                        32'h4000, 4, 3'b010, 0, 1, 3'b111);
    send("R8 index 7 machine",                     32'h4000, 4, 3'b001, 1, 0, 3'b000);
    cfg[0] = 8'h9D;
    send("R8 index 13 machine",                    32'h4000, 4, 3'b100, 1, 1, 3'b101);
    cfg[0] = 8'h1D;
    send("R9 index 5 user write",                  32'h4000, 4, 3'b010, 0, 0, 3'b101);
    cfg[0] = 8'h9F;
    send("R8 index 15 machine write",              32'h4000, 4, 3'b010, 1, 0, 3'b001);
    send("R9 index 15 user read",                  32'h4000, 4, 3'b001, 0, 1, 3'b001);
    cfg[0] = 8'h00;
    send("R10 lockdown machine data",              32'h9000, 4, 3'b011, 1, 1, 3'b011);
    send("R10 lockdown machine exec",              32'h9000, 4, 3'b100, 1, 0, 3'b000);
    send("R10 lockdown user",                      32'h9000, 4, 3'b001, 0, 0, 3'b000);
    lockdown = 1'b0;
    cfg[0] = 8'h9A;
    send("R7 locked W-only entry machine exec",    32'h4000, 4, 3'b100, 1, 0, 3'b010);

    cfg[0] = 8'h19;
    deny_default = 1'b1;
    send("R10 deny-all spares matched entry",      32'h4000, 4, 3'b001, 0, 1, 3'b001);
    cfg[0] = 8'h00;
    send("R10 deny-all machine",                   32'h9000, 4, 3'b001, 1, 0, 3'b000);
    deny_default = 1'b0;
    send("R1 all off user",                        32'h4000, 4, 3'b001, 0, 0, 3'b000);
    send("R1 all off machine",                     32'h4000, 4, 3'b111, 1, 1, 3'b111);

    req_valid = 1'b0;
    req_machine = 1'b0;
    req_addr = 32'h4000;
    repeat (3) @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0 || rsp_allow !== 1'b1 || rsp_perm !== 3'b111) begin
      errors++;
      $display("FAIL R12 idle hold %0b/%0b/%0d expected 0/1/7",
               rsp_valid, rsp_allow, rsp_perm);
    end
    checks++;
    if (q_tag.size() != 0) begin
      errors++;
      $display("FAIL R12 missing results %0d expected 0", q_tag.size());
    end
    finish_up();
  end
endmodule